// File: doc/BRIEF.md
# Interleave Address Sequencer

This block produces the memory address stream for one DMA channel working in interleave mode. Software-side logic hands it a start address, the total number of 16-byte quadwords to move, the length of each transferred run and the length of each gap. After a start, the block offers one quadword address at a time on a valid/ready handshake. When a run is complete, the address jumps over the gap. This repeats until the total count has been delivered, and a one-cycle done pulse marks the end.

Only the gapped address pattern is generated here. Data movement and memory are handled elsewhere. The total counter advances only on delivered quadwords, so the last delivered quadword may fall partway through a run. Two degenerate setups resolve without issuing any address: an empty transfer ends with done, and a zero run length raises a configuration error.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, beat_valid, busy, done and cfg_err are all low.
- R2: A start accepted while idle, with cfg_mode equal to 2 and nonzero total and run, raises beat_valid on the clock edge that samples start. The first address is cfg_addr with bits 3:0 forced to zero.
- R3: Inside a run, each accepted beat (beat_valid and beat_ready both high at an edge) advances beat_addr by 16.
- R4: The beat that completes a run of cfg_run quadwords advances beat_addr by 16 × (cfg_skip + 1), and a new run of cfg_run quadwords begins.
- R5: Exactly cfg_total beats are accepted. Skipped quadwords do not count, and the last beat may fall partway through a run.
- R6: done is high for exactly one cycle, starting on the edge that accepts the final beat. beat_valid and busy are low in that cycle.
- R7: A start with cfg_total equal to 0 produces a one-cycle done pulse on the sampling edge and issues no beat.
- R8: A start with nonzero cfg_total and cfg_run equal to 0 produces a one-cycle cfg_err pulse on the sampling edge, issues no beat and gives no done.
- R9: While beat_valid is high and beat_ready is low, beat_addr and beat_valid hold their values.
- R10: While busy, start and any change to the configuration inputs have no effect on the address sequence or on the beat count.
- R11: With cfg_skip equal to 0, the addresses are contiguous across run boundaries.
- R12: A start with cfg_mode other than 2 is ignored: no beat, no done and no cfg_err.
- R13: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start request, sampled while idle |
| cfg_mode | input | 2 | Channel mode; only value 2 (interleave) starts |
| cfg_addr | input | ADDR_W | Start byte address; bits 3:0 ignored |
| cfg_total | input | TOTAL_W | Total quadwords to transfer |
| cfg_run | input | RUN_W | Quadwords per transferred run |
| cfg_skip | input | SKIP_W | Quadwords skipped between runs |
| beat_valid | output | 1 | Address offered |
| beat_ready | input | 1 | Consumer accepts the offered address |
| beat_addr | output | ADDR_W | Current quadword byte address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | One-cycle pulse for a zero run length |

## Verification
All responses come out of registers. beat_valid, done and cfg_err change on the edge that samples start, and each new address appears on the edge that accepts the previous beat. done appears on the edge that accepts the final beat. The bench drives inputs and samples outputs on falling edges, so every result it checks is due at the first falling edge after the rising edge that caused it. A reference walk of the run/skip pattern in the bench is advanced only at falling edges where valid and ready were both high, and each offered address is compared against it. A stalled cycle is followed by a check that the address has not moved.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned QW_SHIFT = 4;
  localparam logic [1:0] MODE_INTERLEAVE = 2'd2;
endpackage

// File: rtl/ilv_seq_ctrl.sv
module ilv_seq_ctrl #(
  parameter int unsigned TOTAL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_ok,
  input  logic [TOTAL_W-1:0] cfg_total,
  input  logic               run_zero,
  input  logic               fire,
  output logic               load,
  output logic               active,
  output logic               done,
  output logic               cfg_err
);
  logic               active_q, active_d;
  logic [TOTAL_W-1:0] remain_q, remain_d;
  logic               done_q, done_d, err_q, err_d;
  logic               idle_start, total_zero, last_beat;

  always_comb begin
    idle_start = !active_q && start_ok;
    total_zero = (cfg_total == '0);
    load       = idle_start && !total_zero && !run_zero;
    last_beat  = fire && (remain_q == TOTAL_W'(1));
    remain_d   = remain_q;
    if (load)      remain_d = cfg_total;
    else if (fire) remain_d = remain_q - TOTAL_W'(1);
    active_d = active_q;
    if (load)           active_d = 1'b1;
    else if (last_beat) active_d = 1'b0;
    done_d = (idle_start && total_zero) || last_beat;
    err_d  = idle_start && !total_zero && run_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      remain_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      if (load || fire) remain_q <= remain_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign active  = active_q;
  assign done    = done_q;
  assign cfg_err = err_q;

  // R5: an active transfer always has quadwords left to deliver
  assert_remain_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (remain_q != '0));
  // R6 / R7: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: an error pulse never coincides with a live transfer
  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!active_q && !done_q));
endmodule

// File: rtl/ilv_run_tracker.sv
module ilv_run_tracker #(
  parameter int unsigned RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  input  logic [RUN_W-1:0] cfg_run,
  input  logic             fire,
  output logic             run_end
);
  logic [RUN_W-1:0] len_q, left_q, left_d;

  always_comb begin
    run_end = (left_q == RUN_W'(1));
    left_d  = left_q;
    if (load)         left_d = cfg_run;
    else if (fire)    left_d = run_end ? len_q : left_q - RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      left_q <= '0;
    end else begin
      if (load)         len_q  <= cfg_run;
      if (load || fire) left_q <= left_d;
    end
  end

  // R4: the run position never reaches zero during a transfer
  assert_run_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (left_q != '0));
endmodule

// File: rtl/ilv_addr_step.sv
module ilv_addr_step
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic              fire,
  input  logic              run_end,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d, step;
  logic [SKIP_W-1:0] skip_q;

  always_comb begin
    step = run_end ? ((ADDR_W'(skip_q) + ADDR_W'(1)) << QW_SHIFT)
                   : (ADDR_W'(1) << QW_SHIFT);
    addr_d = addr_q;
    if (load)      addr_d = {cfg_addr[ADDR_W-1:QW_SHIFT], {QW_SHIFT{1'b0}}};
    else if (fire) addr_d = addr_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      skip_q <= '0;
    end else begin
      if (load)         skip_q <= cfg_skip;
      if (load || fire) addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  // R2: every generated address is quadword aligned
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q[QW_SHIFT-1:0] == '0);
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TOTAL_W = 16,
  parameter int unsigned RUN_W   = 8,
  parameter int unsigned SKIP_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         cfg_mode,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [TOTAL_W-1:0] cfg_total,
  input  logic [RUN_W-1:0]   cfg_run,
  input  logic [SKIP_W-1:0]  cfg_skip,
  output logic               beat_valid,
  input  logic               beat_ready,
  output logic [ADDR_W-1:0]  beat_addr,
  output logic               busy,
  output logic               done,
  output logic               cfg_err
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       start_ok, fire, load, active, run_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign start_ok   = start && (cfg_mode == MODE_INTERLEAVE);
  assign beat_valid = active;
  assign busy       = active;
  assign fire       = active && beat_ready;

  ilv_seq_ctrl #(.TOTAL_W(TOTAL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start_ok(start_ok), .cfg_total(cfg_total),
    .run_zero(cfg_run == '0), .fire(fire), .load(load), .active(active),
    .done(done), .cfg_err(cfg_err)
  );

  ilv_run_tracker #(.RUN_W(RUN_W)) u_run (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .active(active),
    .cfg_run(cfg_run), .fire(fire), .run_end(run_end)
  );

  ilv_addr_step #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W)) u_addr (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .cfg_addr(cfg_addr),
    .cfg_skip(cfg_skip), .fire(fire), .run_end(run_end), .addr(beat_addr)
  );

  // R9: a stalled beat keeps its address and stays offered
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr)));
  // R6: done never overlaps an offered beat
  assert_done_no_beat_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> !beat_valid);
endmodule

// File: tb/ilv_addr_gen_test.sv
module ilv_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cfg_mode = 2'd2;
  logic [31:0] cfg_addr = '0;
  logic [15:0] cfg_total = '0;
  logic [7:0]  cfg_run = '0;
  logic [7:0]  cfg_skip = '0;
  logic        beat_ready = 1'b0;
  logic        beat_valid, busy, done, cfg_err;
  logic [31:0] beat_addr;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_addr(cfg_addr), .cfg_total(cfg_total), .cfg_run(cfg_run),
    .cfg_skip(cfg_skip), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung act=%0d exp=<100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic launch(logic [1:0] m, logic [31:0] a, int tot, int run, int skp);
    @(negedge clk);
    cfg_mode = m; cfg_addr = a; cfg_total = 16'(tot);
    cfg_run = 8'(run); cfg_skip = 8'(skp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Walks the expected run/skip pattern; pat 1 stalls every third cycle,
  // poke injects a start with altered configuration mid-transfer (R10).
  task automatic xfer(string req, logic [31:0] a, int tot, int run, int skp,
                      int pat, bit poke);
    logic [31:0] exp_a, prev_a;
    int rl, got, k;
    bit prev_stall;
    exp_a = {a[31:4], 4'h0};
    rl = run; got = 0; k = 0; prev_stall = 0; prev_a = '0;
    launch(2'd2, a, tot, run, skp);
    while (got < tot && k < 5000) begin
      chk(req, "R2/R5 beat_valid while beats remain", 64'(beat_valid), 64'd1);
      if (prev_stall) chk("R9", "addr held over stall", 64'(beat_addr), 64'(prev_a));
      beat_ready = (pat == 0) || ((k % 3) != 1);
      start = poke && (k == 2);
      if (poke && k == 2) begin
        cfg_addr = 32'hDEAD_0000; cfg_total = 16'd1; cfg_run = 8'd7; cfg_skip = 8'd9;
      end
      if (beat_ready) begin
        chk(req, "R3/R4 beat address", 64'(beat_addr), 64'(exp_a));
        got++;
        if (rl == 1) begin exp_a = exp_a + 32'(16 * (skp + 1)); rl = run; end
        else begin exp_a = exp_a + 32'd16; rl--; end
      end
      prev_stall = !beat_ready;
      prev_a = beat_addr;
      k++;
      @(negedge clk);
      start = 1'b0;
    end
    beat_ready = 1'b0;
    chk("R6", "done after final beat", 64'(done), 64'd1);
    chk("R5", "no beat after total", 64'(beat_valid), 64'd0);
    chk("R6", "busy low at done", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R6", "done single cycle", 64'(done), 64'd0);
    chk("R5", "still no beat", 64'(beat_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1", "beat_valid after reset", 64'(beat_valid), 64'd0);
    chk("R1", "busy after reset", 64'(busy), 64'd0);
    chk("R1", "done after reset", 64'(done), 64'd0);
    chk("R1", "cfg_err after reset", 64'(cfg_err), 64'd0);
  endtask

  task automatic t_total_zero();
    launch(2'd2, 32'h100, 0, 3, 1);
    chk("R7", "done for empty transfer", 64'(done), 64'd1);
    chk("R7", "no beat for empty transfer", 64'(beat_valid), 64'd0);
    @(negedge clk);
    chk("R7", "done single cycle", 64'(done), 64'd0);
    chk("R7", "still no beat", 64'(beat_valid), 64'd0);
  endtask

  task automatic t_run_zero();
    launch(2'd2, 32'h200, 4, 0, 1);
    chk("R8", "cfg_err on zero run", 64'(cfg_err), 64'd1);
    chk("R8", "no beat on zero run", 64'(beat_valid), 64'd0);
    chk("R8", "no done on zero run", 64'(done), 64'd0);
    @(negedge clk);
    chk("R8", "cfg_err single cycle", 64'(cfg_err), 64'd0);
    chk("R8", "still idle", 64'(busy), 64'd0);
  endtask

  task automatic t_bad_mode();
    launch(2'd0, 32'h300, 4, 2, 1);
    chk("R12", "no beat in normal mode", 64'(beat_valid), 64'd0);
    chk("R12", "no done in normal mode", 64'(done), 64'd0);
    chk("R12", "no err in normal mode", 64'(cfg_err), 64'd0);
    launch(2'd1, 32'h300, 4, 0, 1);
    chk("R12", "no err in chain mode", 64'(cfg_err), 64'd0);
    chk("R12", "no beat in chain mode", 64'(beat_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    xfer("R4", 32'h0000_1000, 8, 3, 2, 0, 1'b0);   // ends mid-run (R5)
    xfer("R11", 32'h0000_4000, 5, 4, 0, 0, 1'b0);
    xfer("R9", 32'h0001_0000, 7, 2, 5, 1, 1'b0);
    xfer("R2", 32'h1234_567B, 3, 1, 255, 0, 1'b0);
    xfer("R13", 32'hFFFF_FFE0, 4, 2, 0, 0, 1'b0);
    xfer("R10", 32'h0002_0000, 6, 2, 1, 0, 1'b1);
    xfer("R3", 32'h0000_0050, 1, 1, 3, 0, 1'b0);
    t_total_zero();
    t_run_zero();
    t_bad_mode();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule